// File: doc/BRIEF.md
# Segmented Carry-Select Chain

This block resolves the carries of a 16-bit half-row of arithmetic cells. Each cell supplies two carry predictions: the carry-out it would produce if its carry-in were 0 and the one it would produce if its carry-in were 1. The chain is split into four short groups of 1, 3, 5 and 7 bits. Each group ripples both hypotheses in parallel, and the real carry-out of the group beneath selects the result. The total delay is roughly the longest group plus one select stage per group, not sixteen ripple stages.

Configuration inputs reshape the chain. A cut at a group boundary turns the groups on either side into independent adders, and the upper one takes its own carry-in bit. An extension option lets a group take over the top bit of the group beneath it, which moves that boundary down by one bit. An extension plus a cut on the top group yields two independent 8-bit adders. The per-bit carries and the group carry-outs are registered under a clock enable. The registered top carry can feed the carry-in of a second chain on the next cycle, so two chains make a 32-bit add in two cycles.

Top module: `csel_carry_chain`

## Requirements
- R1: While reset is asserted and at the first edge after it, `carry_q` and `grp_cout_q` are all zero.
- R2: With no cut active, each carry obeys `carry[i] = carry[i-1] ? hi_pred[i] : lo_pred[i]`, where `carry[-1]` is `chain_cin`. `lo_pred[i]` is the bit's carry-out for carry-in 0 and `hi_pred[i]` is its carry-out for carry-in 1.
- R3: Group g (g = 0..3) has length 2g+1 and base bit g*g, giving bits 0, 1-3, 4-8 and 9-15. `grp_cout_q[g]` is the carry of the top bit group g owns, so without extensions it is bits 0, 3, 8 and 15.
- R4: When `cut_en[g-1]` is 1 (g = 1..3), the lowest bit that group g owns takes `cut_cin[g-1]` as its carry-in instead of the carry from below. The bits below are unaffected.
- R5: When `ext_en[g-1]` is 1, group g owns bit g*g-1 as its lowest bit. With no cut this leaves every carry unchanged, and `grp_cout_q[g-1]` becomes the carry of bit g*g-2.
- R6: With `ext_en[2]` and `cut_en[2]` both 1, bits 8-15 form an independent adder whose carry-in is `cut_cin[2]`. `grp_cout_q[2]` equals `carry_q[7]`.
- R7: With `ext_en[0]` set, group 0 owns no bit and `grp_cout_q[0]` equals `chain_cin`. If `cut_en[0]` is also set, bit 0 uses `cut_cin[0]` as its carry-in.
- R8: Outputs update on the rising edge at which `en` is 1 and are visible after that edge. When `en` is 0, they hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output register enable |
| lo_pred | input | 16 | Per-bit carry-out predicted for carry-in 0 |
| hi_pred | input | 16 | Per-bit carry-out predicted for carry-in 1 |
| chain_cin | input | 1 | Carry-in to bit 0 |
| cut_en | input | 3 | Bit g-1 cuts the chain below group g |
| ext_en | input | 3 | Bit g-1 lets group g absorb the top bit below it |
| cut_cin | input | 3 | Bit g-1 is the carry-in for group g when it is cut |
| carry_q | output | 16 | Registered per-bit carries |
| grp_cout_q | output | 4 | Registered carry-out of each group |

## Verification
Every result has exactly one register between the inputs and the ports. The carries and group carry-outs for a vector therefore appear after the first rising edge at which `en` is high. The bench applies each vector on a falling edge and samples on the next falling edge, half a period after the capturing edge. It compares the result against a bench ripple model in which cuts reset the carry. For the hold checks, the bench drops `en`, changes every input, lets one rising edge pass, and checks at the following falling edge that the previous result is still on the ports.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  // number of bits in group g: 1, 3, 5, 7, ...
  function automatic int grp_len(input int g);
    return 2 * g + 1;
  endfunction

  // first bit of group g: running sum of odd lengths is g squared
  function automatic int grp_base(input int g);
    return g * g;
  endfunction
endpackage

// File: rtl/csel_group.sv
`timescale 1ns/1ps
// One short group. Slot 0 is the optional borrowed bit (top bit of the
// group below); slots 1..LEN are the group's own bits.
module csel_group #(
  parameter int LEN = 3
) (
  input  logic         borrow,
  input  logic         gcin,
  input  logic [LEN:0] lo,
  input  logic [LEN:0] hi,
  output logic [LEN:0] car
);
  logic [LEN:0] k0;
  logic [LEN:0] k1;

  // ripple both carry-in hypotheses across the active slots
  always_comb begin
    logic started;
    started = 1'b0;
    k0 = '0;
    k1 = '0;
    for (int j = 0; j <= LEN; j++) begin
      if (j != 0 || borrow) begin
        if (!started) begin
          k0[j] = lo[j];
          k1[j] = hi[j];
          started = 1'b1;
        end else begin
          k0[j] = k0[j-1] ? hi[j] : lo[j];
          k1[j] = k1[j-1] ? hi[j] : lo[j];
        end
      end
    end
  end

  // real carry-in picks one hypothesis per slot
  always_comb begin
    for (int j = 0; j <= LEN; j++) begin
      car[j] = gcin ? k1[j] : k0[j];
    end
  end
endmodule

// File: rtl/csel_link.sv
`timescale 1ns/1ps
// Boundary between group g-1 (below) and group g (above).
module csel_link (
  input  logic cut,
  input  logic ext,
  input  logic seg_cin,
  input  logic prev_top,
  input  logic prev_sub,
  input  logic up_slot0,
  output logic gcin,
  output logic bnd_carry,
  output logic low_cout
);
  logic below_c;

  always_comb begin
    below_c   = ext ? prev_sub : prev_top;
    gcin      = cut ? seg_cin : below_c;
    bnd_carry = ext ? up_slot0 : prev_top;
    low_cout  = below_c;
  end
endmodule

// File: rtl/csel_outreg.sv
`timescale 1ns/1ps
module csel_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (en) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  // R8: a disabled edge leaves the outputs untouched
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/csel_carry_chain.sv
`timescale 1ns/1ps
module csel_carry_chain
  import csel_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [NGRP*NGRP-1:0]      lo_pred,
  input  logic [NGRP*NGRP-1:0]      hi_pred,
  input  logic                      chain_cin,
  input  logic [NGRP-2:0]           cut_en,
  input  logic [NGRP-2:0]           ext_en,
  input  logic [NGRP-2:0]           cut_cin,
  output logic [NGRP*NGRP-1:0]      carry_q,
  output logic [NGRP-1:0]           grp_cout_q
);
  localparam int WIDTH = NGRP * NGRP;
  localparam int NB    = NGRP - 1;

  logic [WIDTH-1:0] carry_d;
  logic [NGRP-1:0]  gcout_d;
  logic [NGRP-1:0]  gcin_w;
  logic [NGRP-1:0]  top_c;
  logic [NB-1:0]    sub_c;
  logic [NB-1:0]    slot0_c;
  logic [NB-1:0]    bnd_c;
  logic [NB-1:0]    lowc_c;
  logic [WIDTH-1:0] seg_start;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LEN  = grp_len(g);
    localparam int BASE = grp_base(g);
    logic [LEN:0] lo_s;
    logic [LEN:0] hi_s;
    logic [LEN:0] car;
    logic         brw;

    if (g == 0) begin : g_first
      logic unused_slot;
      assign lo_s        = {lo_pred[BASE+LEN-1:BASE], 1'b0};
      assign hi_s        = {hi_pred[BASE+LEN-1:BASE], 1'b0};
      assign brw         = 1'b0;
      assign gcin_w[g]   = chain_cin;
      assign sub_c[g]    = chain_cin;
      assign unused_slot = car[0];
    end else begin : g_rest
      assign lo_s = lo_pred[BASE+LEN-1:BASE-1];
      assign hi_s = hi_pred[BASE+LEN-1:BASE-1];
      assign brw  = ext_en[g-1];
      assign slot0_c[g-1] = car[0];
      assign carry_d[BASE+LEN-2:BASE] = car[LEN-1:1];
      if (g < NGRP - 1) begin : g_sub
        assign sub_c[g] = car[LEN-1];
      end
      csel_link u_link (
        .cut       (cut_en[g-1]),
        .ext       (ext_en[g-1]),
        .seg_cin   (cut_cin[g-1]),
        .prev_top  (top_c[g-1]),
        .prev_sub  (sub_c[g-1]),
        .up_slot0  (slot0_c[g-1]),
        .gcin      (gcin_w[g]),
        .bnd_carry (bnd_c[g-1]),
        .low_cout  (lowc_c[g-1])
      );

      // R4: a cut boundary starts its segment from the local carry-in
      assert_cut_start_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_en[g-1] && ext_en[g-1]) |->
          carry_d[BASE-1] == (cut_cin[g-1] ? hi_pred[BASE-1] : lo_pred[BASE-1]));
      assert_cut_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_en[g-1] && !ext_en[g-1]) |->
          carry_d[BASE] == (cut_cin[g-1] ? hi_pred[BASE] : lo_pred[BASE]));
    end

    assign top_c[g] = car[LEN];

    if (g == NGRP - 1) begin : g_last
      assign carry_d[BASE+LEN-1] = car[LEN];
      assign gcout_d[g]          = car[LEN];
    end else begin : g_mid
      assign carry_d[BASE+LEN-1] = bnd_c[g];
      assign gcout_d[g]          = lowc_c[g];
    end

    csel_group #(.LEN(LEN)) u_grp (
      .borrow (brw),
      .gcin   (gcin_w[g]),
      .lo     (lo_s),
      .hi     (hi_s),
      .car    (car)
    );
  end

  // bits whose carry-in comes from a cut rather than from the bit below
  always_comb begin
    seg_start = '0;
    for (int g = 1; g < NGRP; g++) begin
      if (cut_en[g-1]) begin
        if (ext_en[g-1]) seg_start[grp_base(g)-1] = 1'b1;
        else             seg_start[grp_base(g)]   = 1'b1;
      end
    end
  end

  // R2: everywhere outside a cut the carries behave as a plain ripple
  assert_bit0_ripple_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_start[0] |-> carry_d[0] == (chain_cin ? hi_pred[0] : lo_pred[0]));
  for (genvar i = 1; i < WIDTH; i++) begin : g_chk
    assert_ripple_equiv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_start[i] |-> carry_d[i] == (carry_d[i-1] ? hi_pred[i] : lo_pred[i]));
  end

  csel_outreg #(.W(WIDTH)) u_carry_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (carry_d),
    .q     (carry_q)
  );

  csel_outreg #(.W(NGRP)) u_cout_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (gcout_d),
    .q     (grp_cout_q)
  );
endmodule

// File: tb/tb_csel_carry_chain.sv
`timescale 1ns/1ps
module tb_csel_carry_chain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] lo_pred, hi_pred;
  logic        chain_cin;
  logic [2:0]  cut_en, ext_en, cut_cin;
  logic [15:0] carry_q;
  logic [3:0]  grp_cout_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [19:0] last_exp;

  always #2.5 clk = ~clk;

  csel_carry_chain dut (
    .clk(clk), .rst_n(rst_n), .en(en), .lo_pred(lo_pred), .hi_pred(hi_pred),
    .chain_cin(chain_cin), .cut_en(cut_en), .ext_en(ext_en), .cut_cin(cut_cin),
    .carry_q(carry_q), .grp_cout_q(grp_cout_q)
  );

  // ripple reference with the carry reset at each cut: {grp_cout, carry}
  function automatic logic [19:0] ref_chain(input logic [15:0] lo, input logic [15:0] hi,
      input logic cin, input logic [2:0] cut, input logic [2:0] ext, input logic [2:0] scin);
    logic [15:0] c;
    logic [3:0]  gc;
    logic        run;
    int          top;
    run = cin;
    for (int i = 0; i < 16; i++) begin
      for (int g = 1; g < 4; g++)
        if (cut[g-1] && i == g * g - int'(ext[g-1])) run = scin[g-1];
      c[i] = run ? hi[i] : lo[i];
      run  = c[i];
    end
    for (int g = 0; g < 3; g++) begin
      top = (g + 1) * (g + 1) - 1 - int'(ext[g]);
      gc[g] = (top < 0) ? cin : c[top];
    end
    gc[3] = c[15];
    return {gc, c};
  endfunction

  task automatic check(input string tag, input logic [19:0] exp);
    n_vec++;
    if ({grp_cout_q, carry_q} !== exp) begin
      n_bad++;
      $display("FAIL %s: got cout=%h carry=%h, expected cout=%h carry=%h",
               tag, grp_cout_q, carry_q, exp[19:16], exp[15:0]);
    end
  endtask

  task automatic apply(input logic [15:0] lo, input logic [15:0] hi, input logic cin,
      input logic [2:0] cut, input logic [2:0] ext, input logic [2:0] scin, input string tag);
    lo_pred = lo; hi_pred = hi; chain_cin = cin;
    cut_en = cut; ext_en = ext; cut_cin = scin; en = 1'b1;
    last_exp = ref_chain(lo, hi, cin, cut, ext, scin);
    @(posedge clk);
    @(negedge clk);
    check(tag, last_exp);
  endtask

  // R8: en low, inputs scrambled, outputs must keep the last result
  task automatic hold_check();
    en = 1'b0;
    lo_pred = $urandom; hi_pred = $urandom; chain_cin = $urandom;
    cut_en = $urandom; ext_en = $urandom; cut_cin = $urandom;
    @(posedge clk);
    @(negedge clk);
    check("R8 hold", last_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b1;
    lo_pred = 16'hffff; hi_pred = 16'hffff; chain_cin = 1'b1;
    cut_en = '0; ext_en = '0; cut_cin = '1;
    repeat (3) @(negedge clk);
    check("R1 reset", 20'h0);
    rst_n = 1'b1;
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 after release", 20'h0);

    // R2: full propagate lets the chain carry-in run to the top
    apply(16'h0000, 16'hffff, 1'b1, 3'b000, 3'b000, 3'b000, "R2 propagate cin=1");
    apply(16'h0000, 16'hffff, 1'b0, 3'b000, 3'b000, 3'b000, "R2 propagate cin=0");
    apply(16'hffff, 16'hffff, 1'b0, 3'b000, 3'b000, 3'b000, "R2 generate");
    // R3: a generate only at bit 3 shows group carry-outs at bits 3, 8, 15
    apply(16'h0008, 16'hfff8, 1'b0, 3'b000, 3'b000, 3'b000, "R3 group edges");
    // R4: cut below group 2 blocks the propagate and injects its own carry
    apply(16'h0000, 16'hffff, 1'b1, 3'b010, 3'b000, 3'b000, "R4 cut kills");
    apply(16'h0000, 16'hffff, 1'b0, 3'b010, 3'b000, 3'b010, "R4 cut injects");
    // R5: extensions alone do not change carries, only group carry-outs
    apply(16'h0010, 16'hfff0, 1'b0, 3'b000, 3'b111, 3'b000, "R5 extend all");
    apply(16'h0000, 16'hffff, 1'b1, 3'b000, 3'b110, 3'b000, "R5 extend upper");
    // R6: two independent 8-bit adders
    apply(16'h0000, 16'hffff, 1'b1, 3'b100, 3'b100, 3'b000, "R6 split 8/8 lower");
    apply(16'h0000, 16'hffff, 1'b0, 3'b100, 3'b100, 3'b100, "R6 split 8/8 upper");
    // R7: group 0 absorbed
    apply(16'h0000, 16'hffff, 1'b1, 3'b000, 3'b001, 3'b000, "R7 group0 empty");
    apply(16'h0000, 16'hffff, 1'b1, 3'b001, 3'b001, 3'b000, "R7 bit0 cut");
    hold_check();

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a, b, gen_m, lo_v, hi_v;
      a = $urandom; b = $urandom;
      gen_m = a & b;
      lo_v = gen_m;
      hi_v = a | b;
      if (n % 3 == 0) begin lo_v = $urandom; hi_v = $urandom; end
      apply(lo_v, hi_v, 1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
            "R2/R3/R4/R5 random");
      if (n % 25 == 0) hold_check();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule